// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block sits on a simple 32-bit register bus and runs single-bit SPI transactions against a NOR flash device. Software loads an address, data bytes and a bit count into byte-wide registers. It then writes a trigger bit into the command register. The engine builds the serial frame, runs it in SPI mode 0 and returns any received byte to a register. It then clears the trigger bit, which software polls to learn that the operation has finished.

Five operations are available:
- a one-byte read at a 24-bit address;
- a one-byte page program;
- a status read;
- a status write;
- a generic shift of up to 48 bits taken from six program-data bytes.

Through the generic shift, software issues any opcode it needs, such as write-enable (0x06) or a 4 KiB sector erase (0x20 followed by three address bytes). A read or a program can advance the address by one when it finishes, so a sequence of byte transfers needs no address rewrite. No trigger is accepted until a key value has been written to an enable register.

Top module: `nor_cmd_engine`

## Requirements
- R1: Command writes are ignored unless the enable register (offset 0x40) holds 0x30. Any other value there locks the engine again.
- R2: Command register (offset 0x00) bit encoding:
  - bit 0: one-byte read
  - bit 1: status read
  - bit 2: generic shift
  - bit 4: one-byte program
  - bit 5: status write
  - bit 7: address auto-increment

  An accepted trigger bit reads back as 1 while its operation runs. The whole register reads back 0 once the operation completes.
- R3: A read sends opcode 0x03 and then the 24-bit address, MSB first. It then gives 8 more clocks with MOSI held low and stores the MISO byte in the read-data register (0x0C). The address bytes sit at 0x10 (bits 7:0), 0x14 (bits 15:8) and 0x18 (bits 23:16).
- R4: A program sends 0x02, then the 24-bit address, then the byte from the write-data register (0x1C), for 40 clocks in total.
- R5: A status read sends 0x05 and then 8 clocks, and stores the MISO byte at 0x08. A status write sends 0x01 and then the write-data byte. Each takes 16 clocks.
- R6: A generic shift sends the number of bits given by the count register (0x04), MSB first, starting from program-data byte 5 (0x34) and moving down to byte 0 (0x20). A count above 48 is treated as 48. A count of 0 completes without asserting chip select.
- R7: A read or program with bit 7 set adds one to the 24-bit address after the transfer, wrapping from 0xFFFFFF to 0. The address is unchanged without bit 7, and unchanged for the other operations.
- R8: SPI mode 0 is used. SCK is low whenever chip select is high. MISO is sampled on rising edges, and MOSI changes only on falling edges. Each SCK half period lasts DIV+1 system clocks, where DIV is the divider register (0x44) captured when the command starts.
- R9: Chip select is low for exactly the frame's bit count of SCK pulses, is high whenever no operation is in progress, and goes high between consecutive commands.
- R10: While an operation runs, new command writes are ignored. Writes to the address and data registers take effect in the registers but do not alter the frame in flight.
- R11: If a command write sets several trigger bits, only the lowest-numbered one runs, and only that bit (plus bit 7) reads back. A write with no trigger bit starts nothing.
- R12: After reset, chip select is high, SCK is low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data (low byte used) |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach from the ports is a register write that lands in the middle of a transfer. This includes a second trigger and an address rewrite while chip select is low, and it needs a slow divider so the write reliably falls inside the frame. The bench sets the divider to 3 and issues the conflicting writes on the cycles right after the trigger. It then compares the captured frame against the original address and checks that no second frame follows.

Address wrap at 0xFFFFFF and zero or oversized bit counts are reached by direct register setup.

A behavioural flash model collects MOSI bits on every SCK rise and answers on MISO from a per-operation response. A per-clock monitor times every SCK half period against the divider.

// File: rtl/nor_eng_pkg.sv
package nor_eng_pkg;

    localparam int BUS_AW   = 8;
    localparam int BUS_DW   = 32;
    localparam int PDAT_N   = 6;
    localparam int FADDR_W  = 24;
    localparam int FADDR_B  = FADDR_W / 8;
    localparam int FRAME_W  = PDAT_N * 8;
    localparam int NBITS_W  = $clog2(FRAME_W + 1);
    localparam int DIV_W    = 8;

    localparam logic [7:0] UNLOCK_KEY = 8'h30;

    // register offsets
    localparam logic [BUS_AW-1:0] OFS_CMD  = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_CNT  = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_STAT = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_RDAT = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_ADR  = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_WDAT = 8'h1C;
    localparam logic [BUS_AW-1:0] OFS_PDAT = 8'h20;
    localparam logic [BUS_AW-1:0] OFS_KEY  = 8'h40;
    localparam logic [BUS_AW-1:0] OFS_DIV  = 8'h44;

    // command bits
    localparam logic [7:0] TRIG_MASK = 8'h37;
    localparam logic [7:0] AUTO_BIT  = 8'h80;

    // flash opcodes
    localparam logic [7:0] FOP_READ = 8'h03;
    localparam logic [7:0] FOP_PROG = 8'h02;
    localparam logic [7:0] FOP_RDSR = 8'h05;
    localparam logic [7:0] FOP_WRSR = 8'h01;

    typedef enum logic [2:0] {
        OP_NONE, OP_READ, OP_RDSR, OP_SHIFT, OP_WRITE, OP_WRSR
    } op_e;

    typedef struct packed {
        logic [FRAME_W-1:0] tx;
        logic [NBITS_W-1:0] nbits;
        logic [DIV_W-1:0]   div;
    } frame_t;

    function automatic op_e pick_op(input logic [7:0] w);
        if (w[0])      return OP_READ;
        else if (w[1]) return OP_RDSR;
        else if (w[2]) return OP_SHIFT;
        else if (w[4]) return OP_WRITE;
        else if (w[5]) return OP_WRSR;
        return OP_NONE;
    endfunction

    function automatic logic [7:0] op_bit(input op_e op);
        case (op)
            OP_READ:  return 8'h01;
            OP_RDSR:  return 8'h02;
            OP_SHIFT: return 8'h04;
            OP_WRITE: return 8'h10;
            OP_WRSR:  return 8'h20;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic frame_t build_frame(
        input op_e                op,
        input logic [FADDR_W-1:0] adr,
        input logic [7:0]         wd,
        input logic [FRAME_W-1:0] pd,
        input logic [7:0]         cnt,
        input logic [DIV_W-1:0]   div
    );
        frame_t f;
        f.div   = div;
        f.tx    = '0;
        f.nbits = '0;
        case (op)
            OP_READ: begin
                f.tx[FRAME_W-1 -: 32] = {FOP_READ, adr};
                f.nbits = NBITS_W'(40);
            end
            OP_WRITE: begin
                f.tx[FRAME_W-1 -: 40] = {FOP_PROG, adr, wd};
                f.nbits = NBITS_W'(40);
            end
            OP_RDSR: begin
                f.tx[FRAME_W-1 -: 8] = FOP_RDSR;
                f.nbits = NBITS_W'(16);
            end
            OP_WRSR: begin
                f.tx[FRAME_W-1 -: 16] = {FOP_WRSR, wd};
                f.nbits = NBITS_W'(16);
            end
            OP_SHIFT: begin
                f.tx    = pd;
                f.nbits = (int'(cnt) > FRAME_W) ? NBITS_W'(FRAME_W) : NBITS_W'(cnt);
            end
            default: ;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/nor_eng_regs.sv
module nor_eng_regs
    import nor_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    output logic [BUS_DW-1:0] rdata,
    input  logic              done,
    input  logic [7:0]        rx_byte,
    output logic              start,
    output frame_t            frame,
    output logic              busy,
    output logic              unlocked
);

    logic [7:0]         cmd_q, cnt_q, stat_q, rdat_q, wdat_q, key_q;
    logic [DIV_W-1:0]   div_q;
    logic [FADDR_W-1:0] fadr_q;
    logic [7:0]         pdat_q [PDAT_N];
    logic [FRAME_W-1:0] pd_flat;
    op_e                op_q;
    op_e                req_op;
    logic [7:0]         wbyte;

    assign wbyte    = wdata[7:0];
    assign req_op   = pick_op(wbyte);
    assign busy     = |(cmd_q & TRIG_MASK);
    assign unlocked = (key_q == UNLOCK_KEY);

    always_comb begin
        for (int i = 0; i < PDAT_N; i++)
            pd_flat[i*8 +: 8] = pdat_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            cnt_q  <= '0;
            stat_q <= '0;
            rdat_q <= '0;
            wdat_q <= '0;
            key_q  <= '0;
            div_q  <= '0;
            fadr_q <= '0;
            op_q   <= OP_NONE;
            start  <= 1'b0;
            frame  <= '0;
            for (int i = 0; i < PDAT_N; i++) pdat_q[i] <= '0;
        end else begin
            start <= 1'b0;
            if (wr) begin
                if (addr == OFS_CMD) begin
                    if (unlocked && !busy && req_op != OP_NONE) begin
                        cmd_q <= op_bit(req_op) | (wbyte & AUTO_BIT);
                        op_q  <= req_op;
                        start <= 1'b1;
                        frame <= build_frame(req_op, fadr_q, wdat_q, pd_flat, cnt_q, div_q);
                    end
                end
                if (addr == OFS_CNT)  cnt_q  <= wbyte;
                if (addr == OFS_WDAT) wdat_q <= wbyte;
                if (addr == OFS_KEY)  key_q  <= wbyte;
                if (addr == OFS_DIV)  div_q  <= wdata[DIV_W-1:0];
                for (int i = 0; i < FADDR_B; i++)
                    if (addr == OFS_ADR + BUS_AW'(4 * i)) fadr_q[i*8 +: 8] <= wbyte;
                for (int i = 0; i < PDAT_N; i++)
                    if (addr == OFS_PDAT + BUS_AW'(4 * i)) pdat_q[i] <= wbyte;
            end
            if (done) begin
                cmd_q <= '0;
                case (op_q)
                    OP_READ: begin
                        rdat_q <= rx_byte;
                        if (cmd_q[7]) fadr_q <= fadr_q + 1'b1;
                    end
                    OP_WRITE: if (cmd_q[7]) fadr_q <= fadr_q + 1'b1;
                    OP_RDSR:  stat_q <= rx_byte;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CMD:  rdata[7:0] = cmd_q;
            OFS_CNT:  rdata[7:0] = cnt_q;
            OFS_STAT: rdata[7:0] = stat_q;
            OFS_RDAT: rdata[7:0] = rdat_q;
            OFS_WDAT: rdata[7:0] = wdat_q;
            OFS_KEY:  rdata[7:0] = key_q;
            OFS_DIV:  rdata[DIV_W-1:0] = div_q;
            default: ;
        endcase
        for (int i = 0; i < FADDR_B; i++)
            if (addr == OFS_ADR + BUS_AW'(4 * i)) rdata[7:0] = fadr_q[i*8 +: 8];
        for (int i = 0; i < PDAT_N; i++)
            if (addr == OFS_PDAT + BUS_AW'(4 * i)) rdata[7:0] = pdat_q[i];
    end

endmodule

// File: rtl/nor_eng_shifter.sv
module nor_eng_shifter
    import nor_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  frame_t     frame,
    input  logic       miso,
    output logic       sck,
    output logic       cs_n,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);

    typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_GAP} sh_e;

    sh_e                st;
    logic [FRAME_W-1:0] tx;
    logic [NBITS_W-1:0] nbits, bit_idx;
    logic [DIV_W-1:0]   div, tick;
    logic               half_done;

    assign half_done = (tick == div);
    assign mosi      = tx[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SH_IDLE;
            tx      <= '0;
            nbits   <= '0;
            bit_idx <= '0;
            div     <= '0;
            tick    <= '0;
            sck     <= 1'b0;
            cs_n    <= 1'b1;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                SH_IDLE: if (start) begin
                    tx      <= frame.tx;
                    nbits   <= frame.nbits;
                    div     <= frame.div;
                    tick    <= '0;
                    bit_idx <= '0;
                    sck     <= 1'b0;
                    if (frame.nbits == '0) done <= 1'b1;
                    else begin
                        cs_n <= 1'b0;
                        st   <= SH_RUN;
                    end
                end
                SH_RUN: if (half_done) begin
                    tick <= '0;
                    if (!sck) begin
                        sck     <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        tx  <= {tx[FRAME_W-2:0], 1'b0};
                        if (bit_idx == nbits - 1'b1) begin
                            cs_n <= 1'b1;
                            st   <= SH_GAP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end else begin
                    tick <= tick + 1'b1;
                end
                SH_GAP: if (half_done) begin
                    tick <= '0;
                    done <= 1'b1;
                    st   <= SH_IDLE;
                end else begin
                    tick <= tick + 1'b1;
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
    import nor_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic [BUS_DW-1:0] reg_wdata,
    output logic [BUS_DW-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic       xfer_start, xfer_done, eng_busy, cmd_unlocked;
    frame_t     xfer_frame;
    logic [7:0] rx_byte;

    nor_eng_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .done     (xfer_done),
        .rx_byte  (rx_byte),
        .start    (xfer_start),
        .frame    (xfer_frame),
        .busy     (eng_busy),
        .unlocked (cmd_unlocked)
    );

    nor_eng_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (xfer_start),
        .frame   (xfer_frame),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .done    (xfer_done),
        .rx_byte (rx_byte)
    );

endmodule

// File: rtl/nor_eng_chk.sv
module nor_eng_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sck,
    input logic mosi,
    input logic busy,
    input logic xfer_done,
    input logic unlocked
);

    // R1
    locked_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> !$rose(busy));

    // R2
    busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !xfer_done) |=> busy);

    // R2
    busy_clears_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !busy);

    // R8
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    // R8
    mosi_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n) && !$fell(sck)) |-> $stable(mosi));

    // R9
    cs_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

endmodule

bind nor_cmd_engine nor_eng_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (spi_cs_n),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .busy      (eng_busy),
    .xfer_done (xfer_done),
    .unlocked  (cmd_unlocked)
);

// File: tb/sim_nor_cmd_engine.sv
module sim_nor_cmd_engine;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck, cs_n, mosi, miso;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // flash model state
    bit   cur_q[$];
    bit   last_q[$];
    bit   exp_q[$];
    int   frames_n = 0;
    int   k = 0;
    int   rx_from = 1000;
    logic [7:0] resp = '0;
    int   cur_div = 0;
    int   fb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_engine u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
    );

    assign miso = (k >= rx_from && k < rx_from + 8) ? resp[7 - (k - rx_from)] : 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge sck) if (cs_n === 1'b0) begin
        cur_q.push_back(mosi);
        k++;
    end
    always @(negedge cs_n) begin
        cur_q.delete();
        k = 0;
    end
    always @(posedge cs_n) if (!rst) begin
        last_q = cur_q;
        frames_n++;
    end

    // per-clock reference timing model
    logic prev_cs = 1'b1, prev_sck = 1'b0;
    int   half_cnt = 0, hi_cnt = 0;
    always @(negedge clk) if (!rst) begin
        if (cs_n && sck) chk(0, "R8 sck high while deselected", sck, 0);
        if (prev_cs && !cs_n) begin
            chk(hi_cnt >= 2, "R9 chip select high gap", hi_cnt, 2);
            half_cnt = 1;
        end else if (!cs_n) begin
            if (sck != prev_sck) begin
                chk(half_cnt == cur_div + 1, "R8 half period", half_cnt, cur_div + 1);
                half_cnt = 1;
            end else half_cnt++;
        end
        hi_cnt = cs_n ? hi_cnt + 1 : 0;
        prev_cs = cs_n;
        prev_sck = sck;
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 20000; i++) begin
            rd(8'h00, d);
            if ((d & 32'h37) == 0) break;
        end
    endtask

    task automatic issue(input logic [7:0] cmdv, input int rxf, input logic [7:0] rsp);
        rx_from = rxf;
        resp = rsp;
        fb = frames_n;
        wr(8'h00, {24'h0, cmdv});
        wait_idle();
    endtask

    task automatic push_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) exp_q.push_back(b[i]);
    endtask

    task automatic set_addr(input logic [23:0] a);
        wr(8'h10, {24'h0, a[7:0]});
        wr(8'h14, {24'h0, a[15:8]});
        wr(8'h18, {24'h0, a[23:16]});
    endtask

    task automatic get_addr(output logic [23:0] a);
        logic [31:0] d;
        rd(8'h10, d); a[7:0] = d[7:0];
        rd(8'h14, d); a[15:8] = d[7:0];
        rd(8'h18, d); a[23:16] = d[7:0];
    endtask

    task automatic check_frame(input string req);
        chk(frames_n == fb + 1 && last_q == exp_q, req, last_q.size(), exp_q.size());
    endtask

    function automatic logic [7:0] mem_at(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    task automatic read_case(input logic [23:0] a, input bit auto, input string req);
        logic [31:0] d;
        logic [23:0] na;
        set_addr(a);
        exp_q.delete();
        push_bits(8'h03, 8); push_bits(a[23:16], 8); push_bits(a[15:8], 8);
        push_bits(a[7:0], 8); push_bits(8'h00, 8);
        issue(auto ? 8'h81 : 8'h01, 32, mem_at(a));
        check_frame({req, " read frame"});
        rd(8'h0C, d);
        chk(d[7:0] == mem_at(a), {req, " read data"}, d, mem_at(a));
        get_addr(na);
        chk(na == (auto ? a + 24'd1 : a), "R7 address after read", na, auto ? a + 24'd1 : a);
    endtask

    initial begin : main
        logic [31:0] d;
        logic [23:0] a;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        frames_n = 0;

        // R12 reset state
        chk(cs_n == 1'b1 && sck == 1'b0, "R12 pins after reset", {cs_n, sck}, 2'b10);
        rd(8'h00, d); chk(d == 0, "R12 cmd after reset", d, 0);
        rd(8'h0C, d); chk(d == 0, "R12 read data after reset", d, 0);
        rd(8'h10, d); chk(d == 0, "R12 address after reset", d, 0);
        rd(8'h44, d); chk(d == 0, "R12 divider after reset", d, 0);

        // R1 locked
        set_addr(24'h000010);
        fb = frames_n;
        wr(8'h00, 32'h01);
        repeat (60) @(negedge clk);
        rd(8'h00, d);
        chk(frames_n == fb && d == 0, "R1 trigger ignored while locked", frames_n - fb, 0);
        wr(8'h40, 32'h31);
        wr(8'h00, 32'h01);
        repeat (60) @(negedge clk);
        chk(frames_n == fb, "R1 wrong key keeps lock", frames_n - fb, 0);
        wr(8'h40, 32'h30);

        // R3 plain read, divider 0
        cur_div = 0; wr(8'h44, 0);
        read_case(24'h123456, 0, "R3");
        // R8 slower clock, R7 wrap
        cur_div = 3; wr(8'h44, 3);
        read_case(24'hFFFFFF, 1, "R7 wrap");
        cur_div = 1; wr(8'h44, 1);
        read_case(24'h000000, 1, "R7 first");
        // second read continues at the incremented address
        exp_q.delete();
        push_bits(8'h03, 8); push_bits(8'h00, 8); push_bits(8'h00, 8);
        push_bits(8'h01, 8); push_bits(8'h00, 8);
        issue(8'h81, 32, mem_at(24'h1));
        check_frame("R7 auto-increment chain");

        // R4 program with auto-increment
        set_addr(24'hABCDEF);
        wr(8'h1C, 32'hA5);
        exp_q.delete();
        push_bits(8'h02, 8); push_bits(8'hAB, 8); push_bits(8'hCD, 8);
        push_bits(8'hEF, 8); push_bits(8'hA5, 8);
        issue(8'h90, 1000, 8'h00);
        check_frame("R4 program frame");
        get_addr(a);
        chk(a == 24'hABCDF0, "R7 address after program", a, 24'hABCDF0);

        // R5 status read
        exp_q.delete();
        push_bits(8'h05, 8); push_bits(8'h00, 8);
        issue(8'h02, 8, 8'hC3);
        check_frame("R5 status read frame");
        rd(8'h08, d);
        chk(d[7:0] == 8'hC3, "R5 status byte", d, 8'hC3);
        // R5 status write, auto bit has no address effect
        wr(8'h1C, 32'h9C);
        exp_q.delete();
        push_bits(8'h01, 8); push_bits(8'h9C, 8);
        issue(8'hA0, 1000, 8'h00);
        check_frame("R5 status write frame");
        get_addr(a);
        chk(a == 24'hABCDF0, "R7 no increment on status write", a, 24'hABCDF0);

        // R6 generic shift
        wr(8'h34, 32'h06); wr(8'h04, 32'd8);
        exp_q.delete(); push_bits(8'h06, 8);
        issue(8'h04, 1000, 8'h00);
        check_frame("R6 write-enable opcode");
        wr(8'h34, 32'h20); wr(8'h30, 32'h01); wr(8'h2C, 32'h20); wr(8'h28, 32'h00);
        wr(8'h04, 32'd32);
        exp_q.delete();
        push_bits(8'h20, 8); push_bits(8'h01, 8); push_bits(8'h20, 8); push_bits(8'h00, 8);
        issue(8'h04, 1000, 8'h00);
        check_frame("R6 sector erase");
        wr(8'h24, 32'h7E); wr(8'h20, 32'h81); wr(8'h04, 32'd60);
        exp_q.delete();
        push_bits(8'h20, 8); push_bits(8'h01, 8); push_bits(8'h20, 8);
        push_bits(8'h00, 8); push_bits(8'h7E, 8); push_bits(8'h81, 8);
        issue(8'h04, 1000, 8'h00);
        check_frame("R6 count clamped to 48");
        wr(8'h04, 32'd12);
        exp_q.delete(); push_bits(8'h20, 8); push_bits(8'h01, 4);
        issue(8'h04, 1000, 8'h00);
        check_frame("R6 partial byte count");
        wr(8'h04, 32'd0);
        issue(8'h04, 1000, 8'h00);
        rd(8'h00, d);
        chk(frames_n == fb && d == 0, "R6 zero count no select", frames_n - fb, 0);

        // R11 several triggers
        set_addr(24'h00ABCD);
        rx_from = 32; resp = mem_at(24'h00ABCD); fb = frames_n;
        wr(8'h00, 32'h13);
        rd(8'h00, d);
        chk(d == 32'h01, "R11 only lowest trigger shown", d, 32'h01);
        wait_idle();
        exp_q.delete();
        push_bits(8'h03, 8); push_bits(8'h00, 8); push_bits(8'hAB, 8);
        push_bits(8'hCD, 8); push_bits(8'h00, 8);
        check_frame("R11 lowest trigger runs");
        issue(8'h80, 1000, 8'h00);
        repeat (40) @(negedge clk);
        rd(8'h00, d);
        chk(frames_n == fb && d == 0, "R11 no trigger bit", frames_n - fb, 0);

        // R10 writes during busy
        cur_div = 3; wr(8'h44, 3);
        set_addr(24'h345678);
        rx_from = 32; resp = mem_at(24'h345678); fb = frames_n;
        wr(8'h00, 32'h01);
        wr(8'h00, 32'h10);
        wr(8'h10, 32'hEE);
        rd(8'h00, d);
        chk(d == 32'h01, "R10 second trigger ignored", d, 32'h01);
        wait_idle();
        exp_q.delete();
        push_bits(8'h03, 8); push_bits(8'h34, 8); push_bits(8'h56, 8);
        push_bits(8'h78, 8); push_bits(8'h00, 8);
        check_frame("R10 frame unchanged by writes");
        rd(8'h0C, d);
        chk(d[7:0] == mem_at(24'h345678), "R10 data from original address", d, mem_at(24'h345678));
        get_addr(a);
        chk(a == 24'h3456EE, "R10 address write took effect", a, 24'h3456EE);
        repeat (100) @(negedge clk);
        chk(frames_n == fb + 1, "R10 no deferred command", frames_n - fb, 1);
        rd(8'h00, d);
        chk(d == 0, "R2 command register clear", d, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule